// File: doc/BRIEF.md
# Dual Voice Sample FIFO

This block buffers voice samples in both directions between an 8-bit host bus and a sample engine. One byte-wide FIFO carries recorded samples from the engine to the host. The other carries playback samples from the host to the engine. Both FIFOs always share one depth, chosen at run time from three sizes. Changing the depth empties both of them.

A single set of empty, half and full flags is brought out. A monitor-select input picks which FIFO drives these flags, and each flag can be inverted on its own. A separate ready output tells the sample engine that playback data is present, so synthesis can begin. When the engine offers a recorded sample while the recording FIFO is full, the sample is discarded and a one-cycle drop pulse follows. The engine is never stalled.

Both FIFOs are show-ahead: the oldest byte is always present on the read-data port. A read strobe moves on to the next byte. Every flag and the ready output depend only on registered occupancy counters, so each one changes in the cycle after the clock edge that accepts an access.

Top module: `voice_fifo_pair`

## Requirements
- R1: After a synchronous reset, both FIFOs are empty and the depth is 128 words. With all flag inversion bits at 0, this gives flag_empty=1, flag_mid=0, flag_full=0, play_ready=0 and rec_drop=0.
- R2: Each FIFO returns bytes in the order in which it accepted them. The oldest stored byte is present on host_rdata (recording FIFO) or eng_pb_data (playback FIFO) whenever that FIFO is not empty.
- R3: depth_sel sets the capacity: 0 gives 128 words, 1 gives 64, and 2 or 3 give 32. The full flag is active exactly when the monitored FIFO holds the capacity, and a FIFO never holds more.
- R4: The mid flag is active exactly when the monitored FIFO holds strictly more than half the capacity.
- R5: The empty flag is active exactly when the monitored FIFO holds no bytes.
- R6: With mon_rec=0 the flags describe the playback FIFO. With mon_rec=1 they describe the recording FIFO.
- R7: Each flag_inv bit makes one flag active-low when it is 1: bit 0 for empty, bit 1 for mid, bit 2 for full. All flags are active-high when the bits are 0.
- R8: An engine sample offered while the recording FIFO is full is not stored, and the FIFO contents stay unchanged. rec_drop is then high for exactly the next cycle.
- R9: A host write to a full playback FIFO is ignored. A read strobe on an empty FIFO is ignored.
- R10: play_ready is high exactly when the playback FIFO holds at least one byte, and it can only rise after a host write.
- R11: In any cycle where depth_sel differs from the depth in force, both FIFOs are cleared, every access in that cycle is ignored, and the new depth takes effect.
- R12: A write and a read in the same cycle on a FIFO that is neither empty nor full leave its occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| depth_sel | input | 2 | Capacity select: 0=128, 1=64, 2/3=32 |
| flag_inv | input | 3 | Per-flag inversion: bit0 empty, bit1 mid, bit2 full |
| mon_rec | input | 1 | Flag source: 0 playback FIFO, 1 recording FIFO |
| host_wr | input | 1 | Host writes host_wdata into the playback FIFO |
| host_wdata | input | 8 | Playback byte from the host |
| host_rd | input | 1 | Host takes the head byte of the recording FIFO |
| host_rdata | output | 8 | Head byte of the recording FIFO |
| eng_rec_wr | input | 1 | Engine offers a recorded sample |
| eng_rec_data | input | 8 | Recorded sample byte |
| eng_pb_rd | input | 1 | Engine takes the head byte of the playback FIFO |
| eng_pb_data | output | 8 | Head byte of the playback FIFO |
| flag_empty | output | 1 | Empty flag of the monitored FIFO |
| flag_mid | output | 1 | More-than-half flag of the monitored FIFO |
| flag_full | output | 1 | Full flag of the monitored FIFO |
| play_ready | output | 1 | Playback FIFO holds data |
| rec_drop | output | 1 | Pulse: a recorded sample was discarded |

## Verification
The assertions assume that reset is held for at least two clock edges, so that every past value they read comes from the reset state. The drop and hold properties apply only when depth_sel matches the depth in force and no read occurs in the same cycle. The clear property covers the other case on its own. The bench holds reset for several cycles and changes depth_sel only rarely, mostly as single-cycle steps with known FIFO contents. Every strobe pattern, including reads from empty FIFOs and writes to full ones, is otherwise left free.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;

    typedef enum logic [1:0] {
        DEPTH_FULL  = 2'd0,
        DEPTH_HALF  = 2'd1,
        DEPTH_QTR   = 2'd2,
        DEPTH_QTR_B = 2'd3
    } depth_e;

    // packed so that bit 0 is empty, bit 1 is mid, bit 2 is full
    typedef struct packed {
        logic full;
        logic mid;
        logic empty;
    } fflags_t;

    function automatic int unsigned cap_of(input logic [1:0] sel, input int unsigned maxd);
        case (depth_e'(sel))
            DEPTH_FULL: return maxd;
            DEPTH_HALF: return maxd / 2;
            default:    return maxd / 4;
        endcase
    endfunction

    function automatic fflags_t flags_of(input int unsigned cnt, input int unsigned cap);
        fflags_t f;
        f.empty = (cnt == 0);
        f.mid   = (cnt > (cap / 2));
        f.full  = (cnt == cap);
        return f;
    endfunction

endpackage

// File: rtl/vfifo_core.sv
module vfifo_core #(
    parameter int W    = 8,
    parameter int MAXD = 128,
    localparam int PTR_W = $clog2(MAXD),
    localparam int CNT_W = $clog2(MAXD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [CNT_W-1:0] cap,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem [MAXD];
    logic [PTR_W-1:0] wp, rp;
    logic             is_full, is_empty, do_wr, do_rd;

    assign is_full  = (count == cap);
    assign is_empty = (count == '0);
    assign do_wr    = wr_en && !is_full && !clear;
    assign do_rd    = rd_en && !is_empty && !clear;
    assign rd_data  = mem[rp];

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] c);
        if (CNT_W'(p) == c - CNT_W'(1))
            return '0;
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= step_ptr(wp, cap);
            if (do_rd) rp <= step_ptr(rp, cap);
            case ({do_wr, do_rd})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/vfifo_flag_out.sv
module vfifo_flag_out
    import vfifo_pkg::*;
(
    input  fflags_t    pb_fl,
    input  fflags_t    rec_fl,
    input  logic       sel_rec,
    input  logic [2:0] inv,
    output fflags_t    out_fl
);
    fflags_t picked;

    always_comb begin
        picked = sel_rec ? rec_fl : pb_fl;
        out_fl = fflags_t'(picked ^ inv);
    end
endmodule

// File: rtl/voice_fifo_pair.sv
module voice_fifo_pair
    import vfifo_pkg::*;
#(
    parameter int W    = 8,
    parameter int MAXD = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   depth_sel,
    input  logic [2:0]   flag_inv,
    input  logic         mon_rec,
    input  logic         host_wr,
    input  logic [W-1:0] host_wdata,
    input  logic         host_rd,
    output logic [W-1:0] host_rdata,
    input  logic         eng_rec_wr,
    input  logic [W-1:0] eng_rec_data,
    input  logic         eng_pb_rd,
    output logic [W-1:0] eng_pb_data,
    output logic         flag_empty,
    output logic         flag_mid,
    output logic         flag_full,
    output logic         play_ready,
    output logic         rec_drop
);
    localparam int CNT_W = $clog2(MAXD + 1);

    logic [1:0]       depth_q;
    logic             depth_chg;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] pb_cnt, rec_cnt;
    fflags_t          pb_fl, rec_fl, shown;

    assign depth_chg = (depth_sel != depth_q);
    assign cap_q     = CNT_W'(cap_of(depth_q, MAXD));

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q  <= DEPTH_FULL;
            rec_drop <= 1'b0;
        end else begin
            depth_q  <= depth_sel;
            rec_drop <= eng_rec_wr && rec_fl.full && !depth_chg;
        end
    end

    vfifo_core #(.W(W), .MAXD(MAXD)) u_pb (
        .clk(clk), .rst(rst), .clear(depth_chg), .cap(cap_q),
        .wr_en(host_wr), .wr_data(host_wdata),
        .rd_en(eng_pb_rd), .rd_data(eng_pb_data),
        .count(pb_cnt)
    );

    vfifo_core #(.W(W), .MAXD(MAXD)) u_rec (
        .clk(clk), .rst(rst), .clear(depth_chg), .cap(cap_q),
        .wr_en(eng_rec_wr), .wr_data(eng_rec_data),
        .rd_en(host_rd), .rd_data(host_rdata),
        .count(rec_cnt)
    );

    assign pb_fl  = flags_of(pb_cnt, cap_q);
    assign rec_fl = flags_of(rec_cnt, cap_q);

    vfifo_flag_out u_flags (
        .pb_fl(pb_fl), .rec_fl(rec_fl), .sel_rec(mon_rec),
        .inv(flag_inv), .out_fl(shown)
    );

    assign flag_empty = shown.empty;
    assign flag_mid   = shown.mid;
    assign flag_full  = shown.full;
    assign play_ready = !pb_fl.empty;
endmodule

// File: rtl/vfifo_checker.sv
module vfifo_checker #(
    parameter int MAXD = 128,
    localparam int CNT_W = $clog2(MAXD + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       depth_sel,
    input logic [1:0]       depth_q,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] pb_cnt,
    input logic [CNT_W-1:0] rec_cnt,
    input logic             host_wr,
    input logic             host_rd,
    input logic             eng_rec_wr,
    input logic             eng_pb_rd,
    input logic             mon_rec,
    input logic [2:0]       flag_inv,
    input logic             flag_empty,
    input logic             play_ready,
    input logic             rec_drop
);
    AST_DEPTH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (depth_sel != depth_q) |=> (pb_cnt == '0 && rec_cnt == '0)); // R11

    AST_REC_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (rec_cnt == cap_q && eng_rec_wr && !host_rd && depth_sel == depth_q)
        |=> (rec_drop && $stable(rec_cnt))); // R8

    AST_PB_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pb_cnt == cap_q && host_wr && !eng_pb_rd && depth_sel == depth_q)
        |=> $stable(pb_cnt)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pb_cnt <= cap_q && rec_cnt <= cap_q)); // R3

    AST_READY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(play_ready) |-> $past(host_wr)); // R10

    AST_SEL_PLAYBACK: assert property (@(posedge clk) disable iff (rst)
        (!mon_rec && flag_inv == 3'b000 && pb_cnt == '0) |-> flag_empty); // R6
endmodule

bind voice_fifo_pair vfifo_checker #(.MAXD(MAXD)) u_chk (
    .clk(clk), .rst(rst), .depth_sel(depth_sel), .depth_q(depth_q),
    .cap_q(cap_q), .pb_cnt(pb_cnt), .rec_cnt(rec_cnt),
    .host_wr(host_wr), .host_rd(host_rd), .eng_rec_wr(eng_rec_wr),
    .eng_pb_rd(eng_pb_rd), .mon_rec(mon_rec), .flag_inv(flag_inv),
    .flag_empty(flag_empty), .play_ready(play_ready), .rec_drop(rec_drop)
);

// File: tb/sim_voice_fifo_pair.sv
`timescale 1ns/1ps
module sim_voice_fifo_pair;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] depth_sel;
    logic [2:0] flag_inv;
    logic       mon_rec, host_wr, host_rd, eng_rec_wr, eng_pb_rd;
    logic [7:0] host_wdata, eng_rec_data, host_rdata, eng_pb_data;
    logic       flag_empty, flag_mid, flag_full, play_ready, rec_drop;

    always #10 clk = ~clk;

    voice_fifo_pair u0 (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .flag_inv(flag_inv),
        .mon_rec(mon_rec), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .eng_rec_wr(eng_rec_wr),
        .eng_rec_data(eng_rec_data), .eng_pb_rd(eng_pb_rd),
        .eng_pb_data(eng_pb_data), .flag_empty(flag_empty), .flag_mid(flag_mid),
        .flag_full(flag_full), .play_ready(play_ready), .rec_drop(rec_drop)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] pbq[$];
    logic [7:0] recq[$];
    logic [1:0] mdep = 2'd0;
    logic [2:0] minv = 3'b000;
    logic       mmon = 1'b0;
    bit         exp_drop = 1'b0;

    function automatic int exp_cap(input logic [1:0] d);
        return (d == 2'd0) ? 128 : (d == 2'd1) ? 64 : 32;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        int cap = exp_cap(mdep);
        int sz  = mmon ? recq.size() : pbq.size();
        string t = (tag != "") ? tag : (minv != 0) ? "R7" : mmon ? "R6" : "";
        chk((t == "") ? "R5 empty" : t, int'(flag_empty), int'((sz == 0) ^ minv[0]));
        chk((t == "") ? "R4 mid" : t, int'(flag_mid), int'((sz > cap / 2) ^ minv[1]));
        chk((t == "") ? "R3 full" : t, int'(flag_full), int'((sz == cap) ^ minv[2]));
        chk((tag == "") ? "R10 ready" : tag, int'(play_ready), int'(pbq.size() != 0));
        chk((tag == "") ? "R8 drop" : tag, int'(rec_drop), int'(exp_drop));
        if (recq.size() > 0) chk((tag == "") ? "R2 rec data" : tag, int'(host_rdata), int'(recq[0]));
        if (pbq.size() > 0)  chk((tag == "") ? "R2 pb data" : tag, int'(eng_pb_data), int'(pbq[0]));
    endtask

    // drive one cycle at a negative edge, advance the model, check at the next negative edge
    task automatic step(input logic hw, input logic [7:0] hd, input logic hr,
                        input logic ew, input logic [7:0] ed, input logic pr,
                        input logic [1:0] ds, input logic mon, input logic [2:0] inv,
                        input string tag);
        host_wr = hw; host_wdata = hd; host_rd = hr;
        eng_rec_wr = ew; eng_rec_data = ed; eng_pb_rd = pr;
        depth_sel = ds; mon_rec = mon; flag_inv = inv;
        exp_drop = 1'b0;
        if (ds != mdep) begin
            pbq.delete(); recq.delete(); mdep = ds;
        end else begin
            int cap = exp_cap(mdep);
            bit rfull = (recq.size() == cap);
            bit pfull = (pbq.size() == cap);
            if (hr && recq.size() > 0) void'(recq.pop_front());
            if (ew && !rfull) recq.push_back(ed);
            exp_drop = ew && rfull;
            if (pr && pbq.size() > 0) void'(pbq.pop_front());
            if (hw && !pfull) pbq.push_back(hd);
        end
        minv = inv; mmon = mon;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #6_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1;
        host_wr = 0; host_wdata = 0; host_rd = 0; eng_rec_wr = 0;
        eng_rec_data = 0; eng_pb_rd = 0; depth_sel = 0; mon_rec = 0; flag_inv = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R3 R9: fill playback to 128 then push one extra
        for (int i = 0; i < 128; i++) step(1, 8'(i), 0, 0, 0, 0, 0, 0, 0, "");
        step(1, 8'hEE, 0, 0, 0, 0, 0, 0, 0, "R9");
        chk("R3 full at 128", int'(flag_full), 1);
        for (int i = 0; i < 128; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");

        // R11 R6 R8: depth 64, overfill recording
        step(1, 8'h11, 0, 1, 8'h22, 0, 1, 1, 0, "R11");
        for (int i = 0; i < 64; i++) step(0, 0, 0, 1, 8'(i * 3), 0, 1, 1, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 8'hA5, 0, 1, 1, 0, "R8");
        for (int i = 0; i < 64; i++) step(0, 0, 1, 0, 0, 0, 1, 1, 0, "R2");

        // R7: depth 32 with every flag inverted
        for (int i = 0; i < 33; i++) step(1, 8'(i + 7), 0, 0, 0, 0, 2, 0, 3'b111, "R7");
        step(1, 8'h00, 0, 0, 0, 0, 3, 0, 3'b101, "R11");

        // R12: simultaneous write and read at a mid level
        for (int i = 0; i < 20; i++) step(1, 8'(i), 0, 0, 0, 0, 3, 0, 0, "");
        for (int i = 0; i < 6; i++) step(1, 8'(100 + i), 0, 0, 0, 1, 3, 0, 0, "R12");
        chk("R12 mid held", int'(flag_mid), 1);

        // R11: depth change with data present
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
        chk("R11 empty after change", int'(flag_empty), 1);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int wb = ((i / 400) % 2 == 0) ? 75 : 30;
            logic [1:0] ds = mdep;
            logic [2:0] iv = minv;
            if ($urandom_range(299) == 0) ds = 2'($urandom_range(3));
            if ($urandom_range(99) == 0) iv = 3'($urandom_range(7));
            step($urandom_range(99) < wb, 8'($urandom), $urandom_range(99) >= wb,
                 $urandom_range(99) < wb, 8'($urandom), $urandom_range(99) >= wb,
                 ds, 1'($urandom_range(1)), iv, "");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule